// File: doc/BRIEF.md
# Threshold Counter Element

This block is a small counting element meant to sit among pattern-matching states in an automaton fabric. A one-bit event input adds one to an internal count on every cycle it is high. A separate one-bit clear input returns the count to zero. The count only ever moves upward or back to zero. Each instance is configured with an integer threshold and an output mode, and a one-bit fire output reports when the count arrives at the threshold.

Three threshold behaviours can be selected. In the sticky mode the fire output stays high until the count is cleared. In the single-shot mode it is high for one cycle and the count then holds. In the recycling mode it is high for one cycle and the count starts again from zero, so it fires once every threshold events. The current count is also brought out so that neighbouring logic can read it. The count and the fire output are both registered, so they change together on the same clock edge.

Top module: `thresh_counter`

## Requirements
- R1: Outside of a clear and a recycling restart, each rising clock edge with `evt_i` high raises `count_o` by exactly one, and an edge with `evt_i` low leaves it unchanged. The count never decreases except to zero.
- R2: An edge with `clr_i` high sets `count_o` to 0 and `fire_o` to 0, whatever `evt_i` and the mode are.
- R3: When `rst_n` is low, `count_o` is 0 and `fire_o` is 0 at once, with no clock edge needed.
- R4: In sticky mode (`mode_i` = 2'b00), `fire_o` goes high on the edge where `count_o` becomes the threshold. It stays high on every following edge until a clear, as long as the mode stays 2'b00. The count holds at the threshold.
- R5: In single-shot mode (`mode_i` = 2'b01, and also 2'b11), `fire_o` is high only for the one cycle after the edge where `count_o` becomes the threshold. The count then holds at the threshold, so no further pulse occurs until a clear.
- R6: In recycling mode (`mode_i` = 2'b10), the edge on which an event would bring the count to the threshold sets `count_o` to 0 and sets `fire_o` high for that one cycle. Counting then resumes from zero.
- R7: A threshold of 0 never raises `fire_o`. The count then climbs to 2^CNT_W and holds there.
- R8: A threshold above 2^CNT_W behaves exactly like a threshold of 2^CNT_W. The count also never goes past the effective threshold in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Count event, adds one per cycle when high |
| clr_i | input | 1 | Synchronous clear of count and fire; wins over `evt_i` |
| thr_i | input | CNT_W+1 | Threshold (0 disables firing) |
| mode_i | input | 2 | 00 sticky, 01 single-shot, 10 recycling, 11 single-shot |
| count_o | output | CNT_W+1 | Current count |
| fire_o | output | 1 | Threshold output |

## Verification
The bench builds the counter with CNT_W = 4. The count ceiling is then 16 and the threshold port is 5 bits wide. At this width a run of a few dozen events is enough to reach saturation with a zero threshold. Values from 17 to 31 exercise the clamping of oversized thresholds. Random runs repeatedly hit every mode's threshold event, including threshold and mode changes while the count is held.

// File: rtl/thresh_counter_pkg.sv
package thresh_counter_pkg;

  typedef enum logic [1:0] {
    MODE_STICKY = 2'b00,
    MODE_SHOT   = 2'b01,
    MODE_RECYC  = 2'b10,
    MODE_SHOT2  = 2'b11
  } tc_mode_e;

  function automatic logic mode_is_sticky(input logic [1:0] m);
    return m == MODE_STICKY;
  endfunction

  function automatic logic mode_is_recycle(input logic [1:0] m);
    return m == MODE_RECYC;
  endfunction

endpackage

// File: rtl/thresh_counter_limit.sv
module thresh_counter_limit #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W:0] thr_i,
  output logic [CNT_W:0] lim_o,
  output logic           armed_o
);
  localparam logic [CNT_W:0] MAXV = (CNT_W+1)'(1) << CNT_W;

  // Effective ceiling: zero threshold counts to the top, oversize is clamped
  function automatic logic [CNT_W:0] eff_limit(input logic [CNT_W:0] t);
    if (t == '0 || t > MAXV) return MAXV;
    return t;
  endfunction

  assign lim_o   = eff_limit(thr_i);
  assign armed_o = (thr_i != '0);
endmodule

// File: rtl/thresh_counter_step.sv
module thresh_counter_step
  import thresh_counter_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W:0] count_q,
  input  logic [CNT_W:0] lim_i,
  input  logic           armed_i,
  input  logic           evt_i,
  input  logic           clr_i,
  input  logic [1:0]     mode_i,
  output logic [CNT_W:0] count_d,
  output logic           adv_o,
  output logic           hit_o,
  output logic           restart_o
);
  logic [CNT_W:0] bumped;
  logic           at_top;

  assign at_top    = (count_q >= lim_i);
  assign adv_o     = evt_i & ~at_top;
  assign bumped    = count_q + (CNT_W+1)'(1);
  assign hit_o     = adv_o & armed_i & (bumped == lim_i);
  assign restart_o = hit_o & mode_is_recycle(mode_i);

  always_comb begin
    if (clr_i || restart_o) count_d = '0;
    else if (adv_o)         count_d = bumped;
    else                    count_d = count_q;
  end
endmodule

// File: rtl/thresh_counter_fire.sv
module thresh_counter_fire
  import thresh_counter_pkg::*;
(
  input  logic       fire_q,
  input  logic       hit_i,
  input  logic       clr_i,
  input  logic [1:0] mode_i,
  output logic       fire_d
);
  always_comb begin
    if (clr_i)                       fire_d = 1'b0;
    else if (mode_is_sticky(mode_i)) fire_d = fire_q | hit_i;
    else                             fire_d = hit_i;
  end
endmodule

// File: rtl/thresh_counter.sv
module thresh_counter
  import thresh_counter_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_i,
  input  logic           clr_i,
  input  logic [CNT_W:0] thr_i,
  input  logic [1:0]     mode_i,
  output logic [CNT_W:0] count_o,
  output logic           fire_o
);
  localparam logic [CNT_W:0] MAXV = (CNT_W+1)'(1) << CNT_W;

  logic [CNT_W:0] count_q, count_d, lim_w;
  logic           fire_q, fire_d;
  logic           armed_w, adv_w, hit_w, restart_w;

  thresh_counter_limit #(.CNT_W(CNT_W)) u_limit (
    .thr_i   (thr_i),
    .lim_o   (lim_w),
    .armed_o (armed_w)
  );

  thresh_counter_step #(.CNT_W(CNT_W)) u_step (
    .count_q   (count_q),
    .lim_i     (lim_w),
    .armed_i   (armed_w),
    .evt_i     (evt_i),
    .clr_i     (clr_i),
    .mode_i    (mode_i),
    .count_d   (count_d),
    .adv_o     (adv_w),
    .hit_o     (hit_w),
    .restart_o (restart_w)
  );

  thresh_counter_fire u_fire (
    .fire_q (fire_q),
    .hit_i  (hit_w),
    .clr_i  (clr_i),
    .mode_i (mode_i),
    .fire_d (fire_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fire_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      fire_q  <= fire_d;
    end
  end

  assign count_o = count_q;
  assign fire_o  = fire_q;

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !restart_w) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) + (CNT_W+1)'(1)));

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0 && !fire_q));

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !clr_i && mode_i == MODE_STICKY) |=> fire_q);

  assert_shot_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !clr_i && (mode_i == MODE_SHOT || mode_i == MODE_SHOT2)) |=>
      (fire_q && count_q == $past(lim_w)));

  assert_recycle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !clr_i && mode_i == MODE_RECYC) |=> (fire_q && count_q == '0));

  assert_zero_thr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_i == '0) |-> !hit_w);

  assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= MAXV);
endmodule

// File: tb/thresh_counter_bench.sv
`timescale 1ns/1ps
module thresh_counter_bench;
  localparam int CW   = 4;
  localparam int TOPV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_i = 1'b0;
  logic          clr_i = 1'b0;
  logic [CW:0]   thr_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic [CW:0]   count_o;
  logic          fire_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_c = 0;
  bit exp_f = 1'b0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  thresh_counter #(.CNT_W(CW)) u_thresh_counter (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_i),
    .thr_i(thr_i), .mode_i(mode_i), .count_o(count_o), .fire_o(fire_o)
  );

  function automatic int ceiling_of(input int t);
    if (t == 0) return TOPV;
    return (t > TOPV) ? TOPV : t;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (int'(count_o) != exp_c || fire_o != exp_f) begin
      n_bad++;
      $display("FAIL %s: count=%0d fire=%0b expected count=%0d fire=%0b",
               tag, count_o, fire_o, exp_c, exp_f);
    end
  endtask

  // One clock: drive inputs, predict, sample one ns after the edge
  task automatic step(input bit e, input bit c);
    int    lim;
    bit    reached;
    string tag;
    evt_i = e;
    clr_i = c;
    lim = ceiling_of(int'(thr_i));
    reached = 1'b0;
    tag = "R1";
    if (c) begin
      exp_c = 0; exp_f = 1'b0; tag = "R2";
    end else begin
      if (e && exp_c < lim) begin
        exp_c = exp_c + 1;
        reached = (thr_i != 0) && (exp_c == lim);
      end
      if (mode_i == 2'b00) exp_f = exp_f | reached;
      else exp_f = reached;
      if (mode_i == 2'b10 && reached) exp_c = 0;
      if (thr_i == 0) tag = "R7";
      else if (int'(thr_i) > TOPV) tag = "R8";
      else if (reached || exp_f) tag = (mode_i == 2'b00) ? "R4" :
                                       (mode_i == 2'b10) ? "R6" : "R5";
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    #12;
    exp_c = 0; exp_f = 1'b0;
    compare("R3");
    @(negedge clk);
    rst_n = 1'b1;

    // R4 sticky, threshold 3
    thr_i = 5'd3; mode_i = 2'b00;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // R5 single-shot, threshold 2, and alternate code 11
    mode_i = 2'b01; thr_i = 5'd2;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    mode_i = 2'b11;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    // R6 recycling, threshold 4, several periods with gaps
    mode_i = 2'b10; thr_i = 5'd4;
    for (int i = 0; i < 14; i++) step(i % 5 != 2, 1'b0);
    // R6 threshold 1 fires every event
    thr_i = 5'd1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    // R2 clear together with an event
    thr_i = 5'd9;
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // R7 zero threshold: climb to ceiling and stay
    thr_i = 5'd0; mode_i = 2'b00;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    // R8 oversize threshold behaves as 16
    thr_i = 5'd27; mode_i = 2'b01;
    for (int i = 0; i < 19; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    thr_i = 5'd16; mode_i = 2'b10;
    for (int i = 0; i < 18; i++) step(1'b1, 1'b0);

    // R3 asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_c = 0; exp_f = 1'b0;
    compare("R3");
    @(negedge clk);
    rst_n = 1'b1;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        thr_i = ($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31))
                                            : 5'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 19) == 0) mode_i = 2'($urandom_range(0, 3));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 24) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule